// File: doc/BRIEF.md
# DMA Channel Register Slave

This block is the register front end of one descriptor-driven DMA channel. A host reaches it through a simple 32-bit register port: one request per cycle, with a byte offset, four byte-enables, a write flag and write data. A read returns its data one cycle later with a valid strobe. The block holds three writable registers: a control/status word, the address of the first control block, and a free debug word. It also mirrors six fields of the descriptor the transfer engine is working on, as read-only registers.

The control/status word is the interesting part. It mixes several kinds of field. Some bits are replaced by the written value. The end and interrupt flags are cleared by writing a one. A channel-reset bit clears the word and the control-block address before the rest of the write takes effect. An abort bit does nothing. Three status bits are driven live by the engine. When a write moves the active bit from 0 to 1, the block sends a one-cycle start pulse to the engine. The engine reports completion and interrupt events back through single-cycle pulses. The interrupt flag drives the channel's interrupt line directly.

Top module: `dmareg_top`

## Requirements
- R1: After reset the status word, the control-block address and the debug word read as 0 (with the engine level inputs low), and `irq`, `start_pulse` and `access_err` are low.
- R2: Reads use these byte offsets: 0x00 status, 0x04 control-block address, 0x08 info, 0x0C source, 0x10 destination, 0x14 length, 0x18 stride, 0x1C next block, 0x20 debug. Offsets 0x08 to 0x1C return the matching `desc_*` input. Any other offset reads 0. Read data appears with `rd_valid` in the cycle after the request.
- R3: A write to offsets 0x08 to 0x1C, or to an undefined offset, changes no register.
- R4: In a status write, the bits in mask 0x30FF0001 (bit 0 active, bits 16-23, bits 28-29) take the written value. All other stored bits keep their value.
- R5: Writing 1 to bit 1 (end) or to bit 2 (interrupt) clears that flag. `irq` follows the interrupt flag, so it goes low in the cycle after the clearing write.
- R6: Writing 1 to bit 31 clears the status word and the control-block address, and then the rest of the same write is applied. Bit 31 always reads 0.
- R7: `start_pulse` is high for exactly the one cycle after a status write that took the active bit from 0 to 1. It stays low for every other write.
- R8: Writing bit 30 (abort) has no effect, and bit 30 always reads 0.
- R9: An access whose byte-enables are not all ones changes no register. It raises `access_err` for the following cycle, and if it is a read it returns 0.
- R10: An `eng_end` pulse sets bit 1 and clears bit 0. An `eng_int` pulse sets bit 2 and raises `irq`. Engine events are applied after a bus write in the same cycle. The status read shows `eng_paused` in bit 4, `eng_held` in bit 5 and `eng_error` in bit 8.
- R11: The debug word at 0x20 stores and returns all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_be | input | 4 | Byte enables; only 4'hF is a full access |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | 32 | Read data |
| access_err | output | 1 | Narrow access was rejected (one cycle) |
| desc_info | input | 32 | Current descriptor info field |
| desc_src | input | 32 | Current source address |
| desc_dst | input | 32 | Current destination address |
| desc_len | input | 32 | Current transfer length |
| desc_stride | input | 32 | Current stride word |
| desc_next | input | 32 | Current next-block address |
| eng_end | input | 1 | Engine finished a block (pulse) |
| eng_int | input | 1 | Engine raises the interrupt flag (pulse) |
| eng_paused | input | 1 | Engine paused status |
| eng_held | input | 1 | Engine held by flow control |
| eng_error | input | 1 | Engine error status |
| start_pulse | output | 1 | Start request to the engine |
| irq | output | 1 | Channel interrupt line |
| cb_addr | output | 32 | Control-block address register |

## Verification
The hardest cases to reach are the ordering inside one status write. These are a reset bit combined with a fresh active bit, and a write-one-to-clear combined with a masked write. The stimulus first uses engine pulses to put the end and interrupt flags in place, and loads a nonzero control-block address. It then issues the combined writes. One case writes the active bit while it is already 1, to show that a reset in that write does not produce a start. Another case sends narrow writes to the debug and status registers, and follows each with full reads, to show that nothing moved.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

  localparam int DW = 32;

  localparam logic [7:0] OFS_CS     = 8'h00;
  localparam logic [7:0] OFS_CB     = 8'h04;
  localparam logic [7:0] OFS_INFO   = 8'h08;
  localparam logic [7:0] OFS_SRC    = 8'h0C;
  localparam logic [7:0] OFS_DST    = 8'h10;
  localparam logic [7:0] OFS_LEN    = 8'h14;
  localparam logic [7:0] OFS_STRIDE = 8'h18;
  localparam logic [7:0] OFS_NEXT   = 8'h1C;
  localparam logic [7:0] OFS_DBG    = 8'h20;

  localparam int B_ACT   = 0;
  localparam int B_END   = 1;
  localparam int B_INT   = 2;
  localparam int B_PAUSE = 4;
  localparam int B_HELD  = 5;
  localparam int B_ERR   = 8;
  localparam int B_ABORT = 30;
  localparam int B_RST   = 31;

  localparam logic [DW-1:0] WR_MASK = 32'h30FF_0001;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CS, SEL_CB, SEL_INFO, SEL_SRC,
    SEL_DST, SEL_LEN, SEL_STRIDE, SEL_NEXT, SEL_DBG
  } rsel_e;

  function automatic rsel_e offset_to_sel(input logic [7:0] ofs);
    case (ofs)
      OFS_CS:     return SEL_CS;
      OFS_CB:     return SEL_CB;
      OFS_INFO:   return SEL_INFO;
      OFS_SRC:    return SEL_SRC;
      OFS_DST:    return SEL_DST;
      OFS_LEN:    return SEL_LEN;
      OFS_STRIDE: return SEL_STRIDE;
      OFS_NEXT:   return SEL_NEXT;
      OFS_DBG:    return SEL_DBG;
      default:    return SEL_NONE;
    endcase
  endfunction

  // Stored status after a bus write: reset first, then flag clears, then mask.
  function automatic logic [DW-1:0] cs_after_write(input logic [DW-1:0] old,
                                                   input logic [DW-1:0] w);
    logic [DW-1:0] v;
    v = w[B_RST] ? '0 : old;
    if (w[B_END]) v[B_END] = 1'b0;
    if (w[B_INT]) v[B_INT] = 1'b0;
    v = (v & ~WR_MASK) | (w & WR_MASK);
    return v;
  endfunction

  // Engine events land on top of whatever the bus wrote this cycle.
  function automatic logic [DW-1:0] cs_after_events(input logic [DW-1:0] v_in,
                                                    input logic end_ev,
                                                    input logic int_ev);
    logic [DW-1:0] v;
    v = v_in;
    if (end_ev) begin
      v[B_END] = 1'b1;
      v[B_ACT] = 1'b0;
    end
    if (int_ev) v[B_INT] = 1'b1;
    return v;
  endfunction

  function automatic logic [DW-1:0] cs_view(input logic [DW-1:0] stored,
                                            input logic paused,
                                            input logic held,
                                            input logic err);
    logic [DW-1:0] v;
    v = stored;
    v[B_PAUSE] = paused;
    v[B_HELD]  = held;
    v[B_ERR]   = err;
    v[B_ABORT] = 1'b0;
    v[B_RST]   = 1'b0;
    return v;
  endfunction

endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
  import dmareg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  output rsel_e             sel,
  output logic              narrow,
  output logic              rd_go,
  output logic              wr_cs,
  output logic              wr_cb,
  output logic              wr_dbg
);

  localparam int LOW_W = 8;

  logic hi_zero;
  logic full;
  logic wr_ok;

  generate
    if (ADDR_W > LOW_W) begin : g_hi
      assign hi_zero = ~|req_addr[ADDR_W-1:LOW_W];
    end else begin : g_nohi
      assign hi_zero = 1'b1;
    end
  endgenerate

  assign sel    = hi_zero ? offset_to_sel(req_addr[LOW_W-1:0]) : SEL_NONE;
  assign full   = &req_be;
  assign narrow = req_valid & ~full;
  assign rd_go  = req_valid & ~req_write;
  assign wr_ok  = req_valid & req_write & full;
  assign wr_cs  = wr_ok & (sel == SEL_CS);
  assign wr_cb  = wr_ok & (sel == SEL_CB);
  assign wr_dbg = wr_ok & (sel == SEL_DBG);

endmodule

// File: rtl/dmareg_word.sv
module dmareg_word #(
  parameter int                W       = 32,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= RST_VAL;
    else if (clr)    q <= '0;
    else if (wr_en)  q <= wdata;
  end

endmodule

// File: rtl/dmareg_cs.sv
module dmareg_cs
  import dmareg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cs,
  input  logic [DW-1:0] wdata,
  input  logic          eng_end,
  input  logic          eng_int,
  output logic [DW-1:0] cs_q,
  output logic          rst_evt,
  output logic          start_pulse,
  output logic          irq
);

  logic [DW-1:0] cs_wr;
  logic [DW-1:0] cs_nxt;
  logic          act_rise;
  logic          start_q;

  assign cs_wr    = wr_cs ? cs_after_write(cs_q, wdata) : cs_q;
  assign cs_nxt   = cs_after_events(cs_wr, eng_end, eng_int);
  assign rst_evt  = wr_cs & wdata[B_RST];
  assign act_rise = wr_cs & ~cs_q[B_ACT] & cs_wr[B_ACT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q    <= '0;
      start_q <= 1'b0;
    end else begin
      cs_q    <= cs_nxt;
      start_q <= act_rise;
    end
  end

  assign start_pulse = start_q;
  assign irq         = cs_q[B_INT];

  // R7
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> !$past(cs_q[B_ACT]));

  // R5
  irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_cs && (wdata[B_INT] || wdata[B_RST])));

  // R10
  end_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_end |=> (cs_q[B_END] && !cs_q[B_ACT]));

endmodule

// File: rtl/dmareg_rdmux.sv
module dmareg_rdmux
  import dmareg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_go,
  input  logic          narrow,
  input  rsel_e         sel,
  input  logic [DW-1:0] cs_rd,
  input  logic [DW-1:0] cb_q,
  input  logic [DW-1:0] dbg_q,
  input  logic [DW-1:0] d_info,
  input  logic [DW-1:0] d_src,
  input  logic [DW-1:0] d_dst,
  input  logic [DW-1:0] d_len,
  input  logic [DW-1:0] d_stride,
  input  logic [DW-1:0] d_next,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mux_val;
  logic          cs_read_q;

  always_comb begin
    case (sel)
      SEL_CS:     mux_val = cs_rd;
      SEL_CB:     mux_val = cb_q;
      SEL_INFO:   mux_val = d_info;
      SEL_SRC:    mux_val = d_src;
      SEL_DST:    mux_val = d_dst;
      SEL_LEN:    mux_val = d_len;
      SEL_STRIDE: mux_val = d_stride;
      SEL_NEXT:   mux_val = d_next;
      SEL_DBG:    mux_val = dbg_q;
      default:    mux_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      cs_read_q <= 1'b0;
    end else begin
      rd_valid  <= rd_go;
      cs_read_q <= rd_go & ~narrow & (sel == SEL_CS);
      if (rd_go) rd_data <= narrow ? '0 : mux_val;
    end
  end

  // R8
  cs_top_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && cs_read_q) |-> (rd_data[B_RST:B_ABORT] == 2'b00));

endmodule

// File: rtl/dmareg_top.sv
module dmareg_top
  import dmareg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              access_err,
  input  logic [31:0]       desc_info,
  input  logic [31:0]       desc_src,
  input  logic [31:0]       desc_dst,
  input  logic [31:0]       desc_len,
  input  logic [31:0]       desc_stride,
  input  logic [31:0]       desc_next,
  input  logic              eng_end,
  input  logic              eng_int,
  input  logic              eng_paused,
  input  logic              eng_held,
  input  logic              eng_error,
  output logic              start_pulse,
  output logic              irq,
  output logic [31:0]       cb_addr
);

  rsel_e         sel;
  logic          narrow, rd_go, wr_cs, wr_cb, wr_dbg;
  logic [DW-1:0] cs_q, cs_rd, cb_q, dbg_q;
  logic          rst_evt;
  logic          err_q;

  dmareg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .sel(sel), .narrow(narrow), .rd_go(rd_go),
    .wr_cs(wr_cs), .wr_cb(wr_cb), .wr_dbg(wr_dbg)
  );

  dmareg_cs u_cs (
    .clk(clk), .rst_n(rst_n), .wr_cs(wr_cs), .wdata(req_wdata),
    .eng_end(eng_end), .eng_int(eng_int), .cs_q(cs_q), .rst_evt(rst_evt),
    .start_pulse(start_pulse), .irq(irq)
  );

  dmareg_word #(.W(DW)) u_cb (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_cb), .clr(rst_evt),
    .wdata(req_wdata), .q(cb_q)
  );

  dmareg_word #(.W(DW)) u_dbg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_dbg), .clr(1'b0),
    .wdata(req_wdata), .q(dbg_q)
  );

  assign cs_rd = cs_view(cs_q, eng_paused, eng_held, eng_error);

  dmareg_rdmux u_rd (
    .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .narrow(narrow), .sel(sel),
    .cs_rd(cs_rd), .cb_q(cb_q), .dbg_q(dbg_q),
    .d_info(desc_info), .d_src(desc_src), .d_dst(desc_dst),
    .d_len(desc_len), .d_stride(desc_stride), .d_next(desc_next),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= narrow;
  end

  assign access_err = err_q;
  assign cb_addr    = cb_q;

  // R9
  narrow_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access_err |-> (cb_q == $past(cb_q) && dbg_q == $past(dbg_q)));

  // R6
  reset_clears_cb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_evt) |-> (cb_q == '0));

endmodule

// File: tb/dmareg_top_tb.sv
`timescale 1ns/1ps
module dmareg_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid, access_err, start_pulse, irq;
  logic [31:0] rd_data, cb_addr;
  logic [31:0] d_info = 32'h1111_0001, d_src = 32'h2222_0002, d_dst = 32'h3333_0003;
  logic [31:0] d_len = 32'h4444_0004, d_stride = 32'h5555_0005, d_next = 32'h6666_0006;
  logic        eng_end = 1'b0, eng_int = 1'b0;
  logic        eng_paused = 1'b0, eng_held = 1'b0, eng_error = 1'b0;

  always #2 clk = ~clk;

  dmareg_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .access_err(access_err),
    .desc_info(d_info), .desc_src(d_src), .desc_dst(d_dst), .desc_len(d_len),
    .desc_stride(d_stride), .desc_next(d_next), .eng_end(eng_end),
    .eng_int(eng_int), .eng_paused(eng_paused), .eng_held(eng_held),
    .eng_error(eng_error), .start_pulse(start_pulse), .irq(irq), .cb_addr(cb_addr)
  );

  int nvec = 0, nbad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  // bench model of the writable state
  logic [31:0] m_cs = '0, m_cb = '0, m_dbg = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] view();
    return m_cs | {23'd0, eng_error, 2'b00, eng_held, eng_paused, 4'd0};
  endfunction

  task automatic bus(input bit wr, input logic [7:0] a, input logic [3:0] be,
                     input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus(1'b0, a, 4'hF, '0);
  endtask

  // Status write: bench restates the rules of R4, R5, R6, R7
  task automatic wr_status(input logic [31:0] w, input string tag);
    bit old_act, exp_start;
    old_act = m_cs[0];
    if (w[31]) begin m_cs = '0; m_cb = '0; end
    if (w[1]) m_cs[1] = 1'b0;
    if (w[2]) m_cs[2] = 1'b0;
    m_cs[0]     = w[0];
    m_cs[23:16] = w[23:16];
    m_cs[29:28] = w[29:28];
    exp_start = !old_act && m_cs[0];
    bus(1'b1, 8'h00, 4'hF, w);
    chk({tag, " start"}, {31'd0, start_pulse}, {31'd0, exp_start});
    chk({tag, " irq"}, {31'd0, irq}, {31'd0, m_cs[2]});
    rd(8'h00, view(), {tag, " status"});
  endtask

  task automatic pulse_end();
    @(negedge clk); eng_end = 1'b1;
    @(negedge clk); eng_end = 1'b0;
    m_cs[1] = 1'b1; m_cs[0] = 1'b0;
  endtask

  task automatic pulse_int();
    @(negedge clk); eng_int = 1'b1;
    @(negedge clk); eng_int = 1'b0;
    m_cs[2] = 1'b1;
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        nvec++; nbad++;
        $display("FAIL R2: unexpected read data got %h expected none", rd_data);
      end else begin
        chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 start", {31'd0, start_pulse}, 32'd0);
    chk("R1 err", {31'd0, access_err}, 32'd0);
    rd(8'h00, 32'd0, "R1 status");
    rd(8'h04, 32'd0, "R1 cb");
    rd(8'h20, 32'd0, "R1 dbg");

    // R2 descriptor mirrors and undefined offsets
    rd(8'h08, d_info, "R2 info");
    rd(8'h0C, d_src, "R2 src");
    rd(8'h10, d_dst, "R2 dst");
    rd(8'h14, d_len, "R2 len");
    rd(8'h18, d_stride, "R2 stride");
    rd(8'h1C, d_next, "R2 next");
    rd(8'h24, 32'd0, "R2 undefined 0x24");
    rd(8'h02, 32'd0, "R2 misaligned 0x02");
    rd(8'hF0, 32'd0, "R2 undefined 0xF0");

    // R11 debug word
    bus(1'b1, 8'h20, 4'hF, 32'hA5A5_5A5A); m_dbg = 32'hA5A5_5A5A;
    rd(8'h20, m_dbg, "R11 dbg");
    bus(1'b1, 8'h04, 4'hF, 32'h1234_5670); m_cb = 32'h1234_5670;
    rd(8'h04, m_cb, "R2 cb");
    chk("R2 cb_addr port", cb_addr, m_cb);

    // R3 read-only and undefined writes
    bus(1'b1, 8'h08, 4'hF, 32'hDEAD_BEEF);
    bus(1'b1, 8'h1C, 4'hF, 32'hDEAD_BEEF);
    bus(1'b1, 8'h40, 4'hF, 32'hDEAD_BEEF);
    rd(8'h08, d_info, "R3 info kept");
    rd(8'h1C, d_next, "R3 next kept");
    rd(8'h04, m_cb, "R3 cb kept");
    rd(8'h20, m_dbg, "R3 dbg kept");
    rd(8'h00, view(), "R3 status kept");

    // R4 mask, R8 abort bit written along
    wr_status(32'h7FAA_FFF0, "R4 masked write");
    wr_status(32'h0000_0001, "R7 rising active");
    wr_status(32'h0055_0001, "R7 active already set");

    // R10 engine events and live status bits
    pulse_end();
    rd(8'h00, view(), "R10 end event");
    pulse_int();
    chk("R10 irq raised", {31'd0, irq}, 32'd1);
    eng_paused = 1'b1; eng_held = 1'b1; eng_error = 1'b1;
    rd(8'h00, view(), "R10 live bits");
    eng_paused = 1'b0; eng_held = 1'b0; eng_error = 1'b0;

    // R5 write-one-to-clear
    wr_status(32'h0055_0002, "R5 clear end");
    wr_status(32'h0000_0004, "R5 clear int");

    // R6 channel reset bit
    bus(1'b1, 8'h04, 4'hF, 32'h0000_0100); m_cb = 32'h0000_0100;
    pulse_end();
    pulse_int();
    wr_status(32'h80CC_0001, "R6 reset with start");
    rd(8'h04, m_cb, "R6 cb cleared");
    wr_status(32'h80AB_0001, "R6 reset while active");

    // R8 abort only
    wr_status(32'h40AB_0001, "R8 abort");

    // R9 narrow accesses
    bus(1'b1, 8'h20, 4'h3, 32'h0000_0000);
    chk("R9 err on narrow write", {31'd0, access_err}, 32'd1);
    bus(1'b1, 8'h00, 4'h1, 32'h0000_0000);
    chk("R9 err on narrow cs write", {31'd0, access_err}, 32'd1);
    exp_q.push_back(32'd0); tag_q.push_back("R9 narrow read");
    bus(1'b0, 8'h04, 4'h7, '0);
    chk("R9 err on narrow read", {31'd0, access_err}, 32'd1);
    rd(8'h20, m_dbg, "R9 dbg kept");
    rd(8'h00, view(), "R9 status kept");
    chk("R9 err clears", {31'd0, access_err}, 32'd0);

    // R7 one-cycle pulse
    wr_status(32'h0000_0000, "R7 drop active");
    bus(1'b1, 8'h00, 4'hF, 32'h0000_0001); m_cs[0] = 1'b1;
    chk("R7 pulse high", {31'd0, start_pulse}, 32'd1);
    @(negedge clk);
    chk("R7 pulse one cycle", {31'd0, start_pulse}, 32'd0);

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      nvec++; nbad++;
      $display("FAIL R2: pending reads got %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule